// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel sample pairs. It watches a bit clock, a frame clock and a serial data line. It understands four framing conventions: right-justified, I2S, left-justified, and a pulse-framed DSP style. A 2-bit format input selects the convention. In right-justified framing, a 2-bit word-length input fixes where the word starts inside the half-frame. Every word arrives MSB first in two's complement, and the left word always comes before the right word.

The three serial pins are sampled by the block's own system clock, which must run several times faster than the bit clock. Edges of the bit clock are found inside that clock domain. Each completed stereo pair is presented as two 24-bit left-aligned samples on a valid/ready output.

The output rules are as follows. A pair stays on the outputs, unchanged, until it is accepted by `out_valid && out_ready` at a clock edge. The audio stream cannot be stalled. So if a new pair completes while an older one is still waiting, the new pair replaces the old one and `out_valid` stays high. After a pair is accepted with no new pair arriving in the same cycle, `out_valid` drops in the next cycle.

Top module: `sar_rx`

## Requirements
- R1: After reset, `out_valid` is 0 and both sample outputs are 0.
- R2: With `fmt` = 2'b10 (left-justified), the half-frame with `lrclk` high holds the left word. Its MSB sits in the first bit slot after the `lrclk` change, and bits are taken on rising `bclk`.
- R3: With `fmt` = 2'b01 (I2S), the half-frame with `lrclk` low holds the left word. Its MSB sits in the second bit slot after the `lrclk` change, and bits are taken on rising `bclk`.
- R4: With `fmt` = 2'b00 (right-justified), `lrclk` high marks left and bits are taken on rising `bclk`. In a 32-slot half-frame, capture begins at slot 8, 12 or 16, counted from 0 at the `lrclk` change. These starts give 24, 20 or 16-bit words for `wlen` = 2'b00, 2'b01, or 2'b10/2'b11.
- R5: With `fmt` = 2'b11 (DSP), bits are taken on falling `bclk`. An `lrclk` high pulse lasting one or more slots comes before each word, and the MSB follows in the first slot with `lrclk` low. The first pulse after reset starts a left word, and later pulses alternate between right and left.
- R6: A word shorter than 24 bits appears left-aligned in its 24-bit output with zeros in the low bits. Outside right-justified mode, bits after the 24th of a word are discarded.
- R7: Exactly one pair is delivered per stereo frame, and both samples change together. A pair is delivered when the right word reaches 24 bits, or else when the next half-frame begins. Nothing is captured until the first left half-frame after reset.
- R8: In left-justified mode, a half-frame may be as short as the word, and `bclk` may stop between words.
- R9: A pending pair holds `out_valid` and its data stable until accepted. A newer pair replaces it. After an acceptance with no new pair, `out_valid` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Frame/channel clock |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt | input | 2 | Framing select: 00 right-justified, 01 I2S, 10 left-justified, 11 DSP |
| wlen | input | 2 | Right-justified word length: 00 = 24, 01 = 20, 1x = 16 |
| out_valid | output | 1 | A sample pair is available |
| out_ready | input | 1 | The consumer accepts the pair this cycle |
| out_left | output | 24 | Left sample, two's complement, left-aligned |
| out_right | output | 24 | Right sample, two's complement, left-aligned |

## Verification
The assertions assume that each level of `bclk` lasts at least two `clk` cycles, so that every bit-clock edge produces exactly one capture strobe. They also assume that `lrclk` and `sdata` change only on the bit-clock edge opposite the capture edge, and never in the same `clk` cycle as a capture edge. The stimulus keeps within these limits. Every pin change is made on the falling edge of `clk`, and each `bclk` level is held for two `clk` cycles. Frame and data changes happen together with the non-capturing `bclk` transition. Between tests the block is reset, and `fmt` and `wlen` change only while reset is active.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } sar_fmt_e;
endpackage

// File: rtl/sar_pin_sampler.sv
// Registers the serial pins in the clk domain and produces a one-cycle capture
// strobe on the selected bit-clock edge, aligned with the registered data.
module sar_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdata,
  input  logic fall_sel,
  output logic cap,
  output logic lr,
  output logic sd
);
  logic b1, b2, l1, s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1 <= 1'b0;
      b2 <= 1'b0;
      l1 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      b1 <= bclk;
      b2 <= b1;
      l1 <= lrclk;
      s1 <= sdata;
    end
  end

  logic rise, fall;
  assign rise = b1 & ~b2;
  assign fall = ~b1 & b2;
  assign cap  = fall_sel ? fall : rise;
  assign lr   = l1;
  assign sd   = s1;
endmodule

// File: rtl/sar_framer.sv
// Tracks slot position and channel per half-frame and decides which bit slots
// are written into which channel word, and when a stereo pair is complete.
module sar_framer
  import sar_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int HALF_SLOTS = 32,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             lr,
  input  logic [1:0]       fmt,
  input  logic [1:0]       wlen,
  output logic             wr_en,
  output logic             wr_right,
  output logic [IDX_W-1:0] wr_idx,
  output logic             commit
);
  localparam int SLOT_W = $clog2(HALF_SLOTS) + 1;
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
  localparam logic [SLOT_W-1:0] S_ZERO   = '0;
  localparam logic [SLOT_W-1:0] S_ONE    = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] S_WORD   = SLOT_W'(WORD_W);
  localparam logic [SLOT_W-1:0] S_LAST   = SLOT_W'(WORD_W - 1);
  localparam logic [SLOT_W-1:0] S_HALF   = SLOT_W'(HALF_SLOTS);
  localparam logic [SLOT_W-1:0] RJ_W24   = SLOT_W'(HALF_SLOTS - WORD_W);
  localparam logic [SLOT_W-1:0] RJ_W20   = SLOT_W'(HALF_SLOTS - WORD_W + 4);
  localparam logic [SLOT_W-1:0] RJ_W16   = SLOT_W'(HALF_SLOTS - WORD_W + 8);

  logic              lr_prev, right_q, locked, dsp_seen, r_open;
  logic [SLOT_W-1:0] slot;

  logic              is_dsp, new_half, in_pulse, half_right, cur_right, lock_now;
  logic [SLOT_W-1:0] slot_inc, cur_slot, start, rel;

  always_comb begin
    is_dsp   = (fmt == FMT_DSP);
    new_half = is_dsp ? (lr & ~lr_prev) : (lr ^ lr_prev);
    in_pulse = is_dsp & lr;
    slot_inc = (slot == SLOT_MAX) ? slot : slot + S_ONE;
    cur_slot = (new_half | in_pulse) ? S_ZERO : slot_inc;
    case (fmt)
      FMT_I2S: half_right = lr;
      FMT_DSP: half_right = dsp_seen & ~right_q;
      default: half_right = ~lr;
    endcase
    cur_right = new_half ? half_right : right_q;
    case (fmt)
      FMT_RJ: begin
        case (wlen)
          2'b00:   start = RJ_W24;
          2'b01:   start = RJ_W20;
          default: start = RJ_W16;
        endcase
      end
      FMT_LJ:  start = S_ZERO;
      default: start = S_ONE;
    endcase
    rel      = cur_slot - start;
    lock_now = locked | (new_half & ~half_right);
    wr_en    = cap & lock_now & ~in_pulse & (cur_slot >= start) & (rel < S_WORD)
             & ((fmt != FMT_RJ) | (cur_slot < S_HALF));
    wr_right = cur_right;
    wr_idx   = rel[IDX_W-1:0];
    commit   = (wr_en & cur_right & (rel == S_LAST)) | (cap & new_half & r_open);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_prev  <= 1'b0;
      right_q  <= 1'b0;
      locked   <= 1'b0;
      dsp_seen <= 1'b0;
      r_open   <= 1'b0;
      slot     <= '0;
    end else if (cap) begin
      lr_prev <= lr;
      slot    <= cur_slot;
      right_q <= cur_right;
      if (new_half && !half_right) locked <= 1'b1;
      if (is_dsp && new_half) dsp_seen <= 1'b1;
      if (commit) r_open <= 1'b0;
      else if (wr_en && cur_right) r_open <= 1'b1;
    end
  end

  // A left word may only start once the preceding right word has been handed on.
  assert_left_after_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_right) |-> (!r_open || commit));
endmodule

// File: rtl/sar_word_acc.sv
// One channel word, filled MSB first at a slot index; index 0 clears the rest.
module sar_word_acc #(
  parameter int WORD_W    = 24,
  parameter int IDX_W     = 5,
  parameter bit TAKE_NEXT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic              bit_in,
  output logic [WORD_W-1:0] view
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] acc_q, acc_nxt;

  always_comb begin
    acc_nxt = acc_q;
    if (wr) begin
      if (idx == '0) acc_nxt = '0;
      acc_nxt[TOP - idx] = bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nxt;
  end

  generate
    if (TAKE_NEXT) begin : g_next
      assign view = acc_nxt;
    end else begin : g_held
      assign view = acc_q;
    end
  endgenerate

  assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == '0) |=> (acc_q[WORD_W-2:0] == '0));
endmodule

// File: rtl/sar_rx.sv
module sar_rx
  import sar_pkg::*;
#(
  parameter int WORD_W     = 24,
  parameter int HALF_SLOTS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic              sdata,
  input  logic [1:0]        fmt,
  input  logic [1:0]        wlen,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_left,
  output logic [WORD_W-1:0] out_right
);
  localparam int IDX_W = $clog2(WORD_W);

  logic             cap, lr, sd;
  logic             wr_en, wr_right, commit;
  logic [IDX_W-1:0] wr_idx;
  logic [WORD_W-1:0] word_view [2];

  sar_pin_sampler u_pins (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fall_sel(fmt == FMT_DSP), .cap(cap), .lr(lr), .sd(sd)
  );

  sar_framer #(.WORD_W(WORD_W), .HALF_SLOTS(HALF_SLOTS), .IDX_W(IDX_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cap(cap), .lr(lr), .fmt(fmt), .wlen(wlen),
    .wr_en(wr_en), .wr_right(wr_right), .wr_idx(wr_idx), .commit(commit)
  );

  // Channel 0 is read from its held word (it may be restarting at commit time);
  // channel 1 is read including the bit written in the commit cycle.
  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      sar_word_acc #(.WORD_W(WORD_W), .IDX_W(IDX_W), .TAKE_NEXT(ch == 1)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_en & (wr_right == (ch == 1))),
        .idx(wr_idx), .bit_in(sd), .view(word_view[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (commit) begin
      out_valid <= 1'b1;
      out_left  <= word_view[0];
      out_right <= word_view[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !commit) |=>
      (out_valid && $stable(out_left) && $stable(out_right)));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !commit) |=> !out_valid);

  assert_deliver_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> out_valid);
endmodule

// File: tb/sim_sar_rx.sv
module sim_sar_rx;
  localparam int HB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0] fmt = 2'b10, wlen = 2'b00;
  logic rdy = 1'b1;
  logic out_valid;
  logic [23:0] out_left, out_right;

  int n_chk = 0, n_fail = 0;
  logic [23:0] rx_l[$], rx_r[$], ex_l[$], ex_r[$];

  always #2 clk = ~clk;

  sar_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .wlen(wlen), .out_valid(out_valid), .out_ready(rdy),
    .out_left(out_left), .out_right(out_right)
  );

  always @(negedge clk)
    if (rst_n && out_valid && rdy) begin
      rx_l.push_back(out_left);
      rx_r.push_back(out_right);
    end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] align(logic [31:0] v, int n);
    if (n >= 24) return 24'(v >> (n - 24));
    return 24'(v << (24 - n));
  endfunction

  function automatic logic [31:0] pat(int k, int n);
    logic [31:0] m, v;
    m = (32'h1 << n) - 32'h1;
    case (k % 4)
      0: v = m;
      1: v = 32'h1 << (n - 1);
      2: v = 32'h1;
      default: v = (32'h9E3779B9 * 32'(k + 3)) ^ (32'(k) << 7);
    endcase
    return v & m;
  endfunction

  task automatic drive_slot(bit lrv, bit sdv, bit dsp);
    lrclk = lrv;
    sdata = sdv;
    repeat (HB) @(negedge clk);
    bclk = dsp ? 1'b0 : 1'b1;
    repeat (HB) @(negedge clk);
    bclk = dsp ? 1'b1 : 1'b0;
  endtask

  task automatic do_reset(logic [1:0] f, logic [1:0] w);
    rst_n = 1'b0;
    fmt = f;
    wlen = w;
    bclk = (f == 2'b11);
    lrclk = 1'b0;
    sdata = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 0);
    chk(out_left == 24'd0 && out_right == 24'd0, "R1 data after reset",
        {8'd0, out_left | out_right}, 0);
    rx_l.delete(); rx_r.delete(); ex_l.delete(); ex_r.delete();
  endtask

  // One half-frame. left selects the channel; pw is the DSP pulse length.
  task automatic send_half(bit left, logic [31:0] v, int n, int h, int pw, int gap);
    bit lrv, sdv, dsp;
    dsp = (fmt == 2'b11);
    repeat (gap) @(negedge clk);
    for (int s = 0; s < h; s++) begin
      sdv = 1'b0;
      case (fmt)
        2'b10: begin lrv = left;  if (s < n) sdv = v[n-1-s]; end
        2'b01: begin lrv = !left; if (s >= 1 && s <= n) sdv = v[n-s]; end
        2'b00: begin lrv = left;  if (s >= h - n) sdv = v[h-1-s]; end
        default: begin
          lrv = (s < pw);
          if (s >= pw && s < pw + n) sdv = v[n-1-(s-pw)];
        end
      endcase
      drive_slot(lrv, sdv, dsp);
    end
  endtask

  task automatic lead_in();
    for (int s = 0; s < 4; s++) drive_slot(fmt == 2'b01, 1'b0, fmt == 2'b11);
  endtask

  task automatic tail();
    if (fmt == 2'b11) begin
      drive_slot(1'b1, 1'b0, 1'b1);
      drive_slot(1'b0, 1'b0, 1'b1);
    end else begin
      for (int s = 0; s < 4; s++) drive_slot(fmt != 2'b01, 1'b0, 1'b0);
    end
  endtask

  task automatic send_frames(int n, int h, int pw, int gap, int nf, int salt);
    for (int k = 0; k < nf; k++) begin
      logic [31:0] lv, rv;
      lv = pat(2 * k + salt, n);
      rv = pat(2 * k + 1 + salt, n);
      send_half(1'b1, lv, n, h, pw, gap);
      send_half(1'b0, rv, n, h, pw, gap);
      ex_l.push_back(align(lv, n));
      ex_r.push_back(align(rv, n));
    end
  endtask

  task automatic run_test(string req, logic [1:0] f, logic [1:0] w, int n, int h,
                          int pw, int gap, int nf);
    do_reset(f, w);
    lead_in();
    send_frames(n, h, pw, gap, nf, n);
    tail();
    repeat (20) @(negedge clk);
    chk(rx_l.size() == nf, {req, " R7 pairs per frame"}, 32'(rx_l.size()), 32'(nf));
    for (int i = 0; i < nf && i < rx_l.size(); i++) begin
      chk(rx_l[i] == ex_l[i], {req, " left"}, {8'd0, rx_l[i]}, {8'd0, ex_l[i]});
      chk(rx_r[i] == ex_r[i], {req, " right"}, {8'd0, rx_r[i]}, {8'd0, ex_r[i]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    run_test("R2 lj24",          2'b10, 2'b00, 24, 32, 0, 0, 5);
    run_test("R6 lj16 zero fill", 2'b10, 2'b00, 16, 32, 0, 0, 4);
    run_test("R8 lj20 tight",    2'b10, 2'b00, 20, 20, 0, 0, 4);
    run_test("R6 lj28 truncate", 2'b10, 2'b00, 28, 32, 0, 0, 4);
    run_test("R8 lj24 gated",    2'b10, 2'b00, 24, 24, 0, 5, 4);
    run_test("R3 i2s24",         2'b01, 2'b00, 24, 32, 0, 0, 4);
    run_test("R3 i2s18",         2'b01, 2'b00, 18, 32, 0, 0, 4);
    run_test("R4 rj24",          2'b00, 2'b00, 24, 32, 0, 0, 4);
    run_test("R4 rj20",          2'b00, 2'b01, 20, 32, 0, 0, 4);
    run_test("R4 rj16",          2'b00, 2'b10, 16, 32, 0, 0, 4);
    run_test("R4 rj16 code3",    2'b00, 2'b11, 16, 32, 0, 0, 4);
    run_test("R5 dsp24",         2'b11, 2'b00, 24, 32, 1, 0, 4);
    run_test("R5 dsp16 long pulse", 2'b11, 2'b00, 16, 32, 2, 0, 4);

    // R9: back-pressure, a newer pair replaces the pending one.
    do_reset(2'b10, 2'b00);
    rdy = 1'b0;
    lead_in();
    send_frames(24, 32, 0, 0, 3, 9);
    tail();
    repeat (10) @(negedge clk);
    chk(out_valid == 1'b1, "R9 valid held", 32'(out_valid), 1);
    chk(out_left == ex_l[2], "R9 latest left kept", {8'd0, out_left}, {8'd0, ex_l[2]});
    chk(out_right == ex_r[2], "R9 latest right kept", {8'd0, out_right}, {8'd0, ex_r[2]});
    chk(rx_l.size() == 0, "R9 nothing taken while stalled", 32'(rx_l.size()), 0);
    rdy = 1'b1;
    repeat (4) @(negedge clk);
    chk(rx_l.size() == 1, "R9 single acceptance", 32'(rx_l.size()), 1);
    if (rx_l.size() > 0)
      chk(rx_l[0] == ex_l[2] && rx_r[0] == ex_r[2], "R9 accepted pair",
          {8'd0, rx_l[0]}, {8'd0, ex_l[2]});
    chk(out_valid == 1'b0, "R9 valid drops after accept", 32'(out_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule